// File: doc/BRIEF.md
# Register Save/Restore Sequencer

This block saves all eight 64-bit general registers onto a stack that grows toward lower addresses, or restores them from it, in one multi-cycle operation. A one-cycle start pulse and an operation select launch the sequence. Data moves one word at a time through a 64-bit memory port with a request/ready handshake. The block reads and writes an eight-entry register file through one read port (combinational data return) and one write port. At completion it issues one write of the new stack pointer.

Before any memory access, the block checks the current stack pointer against a lower and an upper stack bound. The check confirms that the whole 64-byte frame fits. If it does not fit, the block pulses a stack fault and changes nothing. On save, the slot that belongs to the stack-pointer register receives the pointer value from before the sequence. On restore, that slot is read but its word is thrown away.

On restore, all eight words are first gathered into a local buffer. Only then is the register file written, so a restore never leaves the registers half updated.

Top module: `regsave_seq`

## Requirements
- R1: On save (`op_i`=0), slot k (k = 0..7) is written at address SP0 − 8·(k+1), where SP0 is the stack pointer at start. Slot k holds register k, except slot 4. The resulting memory order, from high address to low, is registers 0, 1, 2, 3, the pointer slot, 5, 6, 7.
- R2: The word stored in slot 4 during a save is SP0, zero-extended. It is not any decremented value.
- R3: On completion, `sp_we_o` pulses once, in the same cycle as `done_o`. It carries SP0 − 64 after a save and SP0 + 64 after a restore.
- R4: On restore (`op_i`=1), read j (j = 0..7) fetches address SP0 + 8·j into register 7 − j. The word from read j = 3 (the pointer slot) is discarded, and register 4 is never written.
- R5: A save is allowed only if SP0 ≥ lo + 64. A restore is allowed only if SP0 + 64 ≤ hi. Both compare unsigned without wrap. Otherwise `fault_o` pulses, and there is no memory request, no register-file write, no stack-pointer write and no busy.
- R6: During a restore, no register-file write happens until all eight reads have completed. A save never writes the register file.
- R7: While a request waits for ready, its address, write enable and write data stay unchanged. Exactly eight handshakes occur per accepted operation.
- R8: `busy_o` rises the cycle after an accepted start and falls in the cycle `done_o` pulses for one cycle. A start that arrives while busy is ignored.
- R9: `fault_o` lasts one cycle, and the block is idle afterwards, so the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse |
| op_i | input | 1 | 0 = save all, 1 = restore all |
| sp_i | input | AW | Current stack pointer |
| stk_lo_i | input | AW | Lowest usable stack address |
| stk_hi_i | input | AW | Upper stack limit (exclusive) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | One-cycle stack fault pulse |
| rf_raddr_o | output | 3 | Register-file read index |
| rf_rdata_i | input | DW | Register-file read data (same cycle) |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 3 | Register-file write index |
| rf_wdata_o | output | DW | Register-file write data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdy_i | input | 1 | Memory accepts or returns the word |
| mem_rdata_i | input | DW | Memory read data, valid with ready |
| sp_we_o | output | 1 | Stack-pointer write enable |
| sp_wdata_o | output | AW | New stack-pointer value |

## Verification
Save and restore pairs are run for every ready pattern: always ready, and ready on every second, third and fourth cycle. Each pattern is combined with several stack positions. The stalling patterns tell a held request apart from one that moves on early. The distinct register contents show whether the slot order or the discarded pointer slot has gone wrong. Stack pointers set exactly at each bound, and 8 bytes short of it, separate a correct room check from one that is off by a word. A second start pulse in mid-save, carrying the other operation, shows whether a start while busy is truly ignored.

// File: rtl/regsave_pkg.sv
package regsave_pkg;
  localparam int SLOTS = 8;
  localparam int IW = $clog2(SLOTS);
  localparam logic [IW-1:0] SP_REG = IW'(4);
  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_COMMIT, ST_FIN} st_t;
endpackage

// File: rtl/regsave_room.sv
module regsave_room #(
  parameter int AW = 16,
  parameter int FRAME = 64
) (
  input  logic [AW-1:0] sp,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic          pop,
  output logic          ok
);
  logic [AW:0] sp_x, lo_x, hi_x;
  assign sp_x = {1'b0, sp};
  assign lo_x = {1'b0, lo};
  assign hi_x = {1'b0, hi};
  // one extra bit keeps the sums from wrapping
  assign ok = pop ? (sp_x + (AW+1)'(FRAME) <= hi_x)
                  : (sp_x >= lo_x + (AW+1)'(FRAME));
endmodule

// File: rtl/regsave_capture.sv
module regsave_capture #(
  parameter int DW = 64,
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end
  assign rdata = store[raddr];
endmodule

// File: rtl/regsave_seq.sv
module regsave_seq
  import regsave_pkg::*;
#(
  parameter int DW = 64,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          op_i,
  input  logic [AW-1:0] sp_i,
  input  logic [AW-1:0] stk_lo_i,
  input  logic [AW-1:0] stk_hi_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          fault_o,
  output logic [2:0]    rf_raddr_o,
  input  logic [DW-1:0] rf_rdata_i,
  output logic          rf_we_o,
  output logic [2:0]    rf_waddr_o,
  output logic [DW-1:0] rf_wdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_rdy_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          sp_we_o,
  output logic [AW-1:0] sp_wdata_o
);
  localparam int WB = DW / 8;
  localparam int FRAME = SLOTS * WB;
  localparam logic [IW-1:0] LAST = IW'(SLOTS - 1);
  localparam logic [IW-1:0] DROP = LAST - SP_REG; // restore read index of pointer slot

  st_t           st;
  logic          op_q;
  logic [AW-1:0] sp0;
  logic [IW-1:0] idx, cidx, nxt;
  logic          room_ok;
  logic [DW-1:0] cap_rdata;
  logic [DW-1:0] nxt_data;

  function automatic logic [AW-1:0] slot_addr(input logic [AW-1:0] base,
                                               input logic pop,
                                               input logic [IW-1:0] k);
    logic [AW-1:0] off;
    off = AW'(k) * AW'(WB);
    return pop ? base + off : base - off - AW'(WB);
  endfunction

  regsave_room #(.AW(AW), .FRAME(FRAME)) u_room (
    .sp(sp_i), .lo(stk_lo_i), .hi(stk_hi_i), .pop(op_i), .ok(room_ok)
  );

  regsave_capture #(.DW(DW), .DEPTH(SLOTS)) u_cap (
    .clk(clk),
    .we(st == ST_XFER && op_q && mem_rdy_i),
    .waddr(idx),
    .wdata(mem_rdata_i),
    .raddr(cidx),
    .rdata(cap_rdata)
  );

  assign nxt = idx + IW'(1);
  assign rf_raddr_o = (st == ST_IDLE) ? '0 : nxt;
  assign nxt_data = (nxt == SP_REG) ? DW'(sp0) : rf_rdata_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
      op_q <= 1'b0;
      sp0 <= '0;
      idx <= '0;
      cidx <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
      fault_o <= 1'b0;
      rf_we_o <= 1'b0;
      rf_waddr_o <= '0;
      rf_wdata_o <= '0;
      mem_req_o <= 1'b0;
      mem_we_o <= 1'b0;
      mem_addr_o <= '0;
      mem_wdata_o <= '0;
      sp_we_o <= 1'b0;
      sp_wdata_o <= '0;
    end else begin
      done_o <= 1'b0;
      fault_o <= 1'b0;
      rf_we_o <= 1'b0;
      sp_we_o <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start_i) begin
            if (room_ok) begin
              op_q <= op_i;
              sp0 <= sp_i;
              idx <= '0;
              busy_o <= 1'b1;
              mem_req_o <= 1'b1;
              mem_we_o <= ~op_i;
              mem_addr_o <= slot_addr(sp_i, op_i, '0);
              mem_wdata_o <= op_i ? '0 : rf_rdata_i;
              st <= ST_XFER;
            end else begin
              fault_o <= 1'b1;
            end
          end
        end
        ST_XFER: begin
          if (mem_rdy_i) begin
            if (idx == LAST) begin
              mem_req_o <= 1'b0;
              mem_we_o <= 1'b0;
              cidx <= '0;
              st <= op_q ? ST_COMMIT : ST_FIN;
            end else begin
              idx <= nxt;
              mem_addr_o <= slot_addr(sp0, op_q, nxt);
              mem_wdata_o <= op_q ? '0 : nxt_data;
            end
          end
        end
        ST_COMMIT: begin
          rf_we_o <= (cidx != DROP);
          rf_waddr_o <= 3'(LAST - cidx);
          rf_wdata_o <= cap_rdata;
          cidx <= cidx + IW'(1);
          if (cidx == LAST) st <= ST_FIN;
        end
        default: begin
          done_o <= 1'b1;
          busy_o <= 1'b0;
          sp_we_o <= 1'b1;
          sp_wdata_o <= op_q ? sp0 + AW'(FRAME) : sp0 - AW'(FRAME);
          st <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/regsave_chk.sv
module regsave_chk #(
  parameter int DW = 64,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          busy_o,
  input logic          done_o,
  input logic          fault_o,
  input logic          rf_we_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          mem_rdy_i,
  input logic          sp_we_o
);
  a_r7_req_held: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o)
                                   && $stable(mem_we_o) && $stable(mem_wdata_o)));
  a_r6_rf_after_reads: assert property (@(posedge clk) disable iff (rst)
    rf_we_o |-> !mem_req_o);
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  a_r8_busy_ends_at_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);
  a_r9_fault_single: assert property (@(posedge clk) disable iff (rst)
    fault_o |=> !fault_o);
  a_r5_fault_quiet: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> (!busy_o && !mem_req_o && !rf_we_o && !sp_we_o));
  a_r3_sp_with_done: assert property (@(posedge clk) disable iff (rst)
    sp_we_o |-> done_o);
endmodule

bind regsave_seq regsave_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o),
  .rf_we_o(rf_we_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdy_i(mem_rdy_i),
  .sp_we_o(sp_we_o)
);

// File: tb/sim_regsave_seq.sv
module sim_regsave_seq;
  localparam int DW = 64;
  localparam int AW = 16;
  localparam logic [AW-1:0] LO = 16'h0100;
  localparam logic [AW-1:0] HI = 16'h0C00;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic op = 1'b0;
  logic [AW-1:0] sp_reg;
  logic busy, done, fault, rf_we, mem_req, mem_we, mem_rdy, sp_we;
  logic [2:0] rf_raddr, rf_waddr;
  logic [DW-1:0] rf_rdata, rf_wdata, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr, sp_wdata;

  logic [DW-1:0] rf [8];
  logic [DW-1:0] mem [512];
  int stall = 0;
  int cyc = 0;
  int hs = 0;
  int early_rf = 0;
  int nchk = 0;
  int nfail = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  regsave_seq #(.DW(DW), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .start_i(start), .op_i(op), .sp_i(sp_reg),
    .stk_lo_i(LO), .stk_hi_i(HI), .busy_o(busy), .done_o(done), .fault_o(fault),
    .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata), .rf_we_o(rf_we),
    .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdy_i(mem_rdy), .mem_rdata_i(mem_rdata), .sp_we_o(sp_we),
    .sp_wdata_o(sp_wdata)
  );

  assign rf_rdata = rf[rf_raddr];
  assign mem_rdata = mem[mem_addr[11:3]];
  assign mem_rdy = (stall == 0) || ((cyc % (stall + 1)) == stall);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rf_we) rf[rf_waddr] <= rf_wdata;
    if (sp_we) sp_reg <= sp_wdata;
    if (mem_req && mem_rdy) begin
      hs <= hs + 1;
      if (mem_we) mem[mem_addr[11:3]] <= mem_wdata;
    end
    if (rf_we && (mem_req || busy == 1'b0)) early_rf <= early_rf + 1;
  end

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int r, input int s, input logic [AW-1:0] b);
    return 64'hC3A5_0000_0000_0000 ^ (64'(r) << 40) ^ (64'(s) << 20) ^ 64'(b) ^ 64'(r * 7);
  endfunction

  // launches an operation; poke pulses a second start mid-run
  task automatic run(input logic o, input bit poke, output bit got_fault);
    @(negedge clk); start = 1'b1; op = o;
    @(negedge clk); start = 1'b0;
    got_fault = fault;
    if (!got_fault) begin
      for (int i = 0; i < 400; i++) begin
        if (poke && i == 3) begin
          start = 1'b1; op = ~o;
        end else start = 1'b0;
        @(negedge clk);
        if (done) break;
      end
      start = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    bit f;
    int h0;
    logic [AW-1:0] b;
    logic [DW-1:0] mark;
    sp_reg = '0;
    for (int r = 0; r < 8; r++) rf[r] = '0;
    for (int a = 0; a < 512; a++) mem[a] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R8 reset busy", 64'(busy), 64'd0);
    check("R8 reset done", 64'(done), 64'd0);
    check("R5 reset fault", 64'(fault), 64'd0);
    check("R7 reset req", 64'(mem_req), 64'd0);

    for (int s = 0; s < 4; s++) begin
      for (int bi = 0; bi < 3; bi++) begin
        stall = s;
        b = LO + 16'd64 + 16'(bi * 16'h0150);
        for (int r = 0; r < 8; r++) rf[r] = pat(r, s, b);
        sp_reg = b;
        h0 = hs;
        run(1'b0, (bi == 1), f);
        check("R5 save accepted", 64'(f), 64'd0);
        check("R7 save handshakes", 64'(hs - h0), 64'd8);
        for (int k = 0; k < 8; k++) begin
          if (k == 4) check("R2 pointer slot", mem[(b - 16'(8 * (k + 1))) >> 3], 64'(b));
          else check("R1 save slot", mem[(b - 16'(8 * (k + 1))) >> 3], pat(k, s, b));
        end
        check("R3 sp after save", 64'(sp_reg), 64'(b - 16'd64));
        check("R6 save leaves rf", rf[7], pat(7, s, b));
        check("R8 idle after save", 64'(busy), 64'd0);

        mark = 64'hDEAD_0000_0000_0000 | 64'(cyc);
        for (int r = 0; r < 8; r++) rf[r] = ~pat(r, s, b);
        rf[4] = mark;
        h0 = hs;
        run(1'b1, 1'b0, f);
        check("R5 restore accepted", 64'(f), 64'd0);
        check("R7 restore handshakes", 64'(hs - h0), 64'd8);
        for (int r = 0; r < 8; r++) begin
          if (r == 4) check("R4 reg4 untouched", rf[r], mark);
          else check("R4 restored reg", rf[r], pat(r, s, b));
        end
        check("R3 sp after restore", 64'(sp_reg), 64'(b));
        check("R6 no early rf write", 64'(early_rf), 64'd0);
      end
    end

    // bounds: save 8 bytes short of room
    stall = 1;
    for (int r = 0; r < 8; r++) rf[r] = 64'(r + 100);
    sp_reg = LO + 16'd56;
    h0 = hs;
    run(1'b0, 1'b0, f);
    check("R5 save fault", 64'(f), 64'd1);
    @(negedge clk);
    check("R9 fault one cycle", 64'(fault), 64'd0);
    check("R5 fault no access", 64'(hs - h0), 64'd0);
    check("R5 fault sp kept", 64'(sp_reg), 64'(LO + 16'd56));
    check("R5 fault rf kept", rf[3], 64'd103);
    check("R5 fault no busy", 64'(busy), 64'd0);

    // restore 8 bytes past the upper bound
    sp_reg = HI - 16'd56;
    run(1'b1, 1'b0, f);
    check("R5 restore fault", 64'(f), 64'd1);
    check("R5 restore fault rf kept", rf[0], 64'd100);

    // restore exactly at the upper bound, right after a fault (R9)
    for (int j = 0; j < 8; j++) mem[((HI - 16'd64) >> 3) + 16'(j)] = 64'(j + 500);
    sp_reg = HI - 16'd64;
    h0 = hs;
    run(1'b1, 1'b0, f);
    check("R9 start after fault", 64'(f), 64'd0);
    check("R5 edge restore handshakes", 64'(hs - h0), 64'd8);
    check("R4 edge reg7", rf[7], 64'd500);
    check("R4 edge reg0", rf[0], 64'd507);
    check("R4 edge reg4 kept", rf[4], 64'd104);
    check("R3 sp at upper bound", 64'(sp_reg), 64'(HI));

    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule